// File: doc/BRIEF.md
# Two-Wire Bus Byte Sequencer

This block paces one byte on a two-wire serial bus. It counts the bits of the current byte on rising edges of the synchronized clock line. It raises a shift request for each data bit and captures the data line on that edge. When the byte is done, it sets a pending flag. The number of data bits per byte is programmable from one to eight through a 3-bit count field. An extra acknowledge clock can be appended after the data bits.

A START pulse begins an address byte. It clears the count field, so an address is always eight bits, and it marks the bus busy. A STOP pulse frees the bus. Arbitration loss is detected elsewhere and arrives as a pulse, which the block latches into a flag. Dropping the enable input releases both pins, forces the flags to their idle values and blocks writes to the data register.

Top module: `i2c_byte_seq`

## Requirements
- R1: The count field sets the data bits per byte to 8 minus its value. The encoding is 000 for 8 bits, 001 for 7 bits, and so on down to 111 for 1 bit. Exactly that many `shift_o` pulses occur per byte, each in the cycle of a rising edge on `scl_in`.
- R2: With `ack_en` high, the byte completes one rising edge after the last data bit. That extra edge produces no `shift_o` pulse.
- R3: On the edge that completes a byte, `pend_o` becomes 1 in the following cycle. In the same cycle `bit_cnt_o` returns to 000. Before that edge, `pend_o` stays 0.
- R4: A START pulse while enabled clears `bit_cnt_o` to 000, sets `busy_o` and restarts the count. The next byte is therefore 8 data bits.
- R5: When a START pulse and a rising `scl_in` edge fall in the same cycle, the START wins. No shift occurs and the edge is not counted.
- R6: A STOP pulse without a START clears `busy_o` in the following cycle.
- R7: An `arb_in` pulse sets `arb_o`. A later data write or START clears it.
- R8: A data write while enabled gives a `load_o` pulse in the same cycle. It clears `pend_o` in the next cycle and restarts the bit count.
- R9: While `en` is 0, `scl_oe` and `sda_oe` are 0. From the next cycle `pend_o` reads 1, and `busy_o` and `arb_o` read 0. A data write produces no `load_o`, leaves `pend_o` at 1 and starts no byte.
- R10: After reset, `pend_o` is 1, `busy_o` and `arb_o` are 0, and `bit_cnt_o` is 000.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| en | input | 1 | Interface enable |
| cnt_wr | input | 1 | Write strobe for the count field |
| cnt_val | input | 3 | Count field value to write |
| ack_en | input | 1 | Append acknowledge clock |
| data_wr | input | 1 | Data register write strobe |
| scl_in | input | 1 | Synchronized clock line sample |
| sda_in | input | 1 | Synchronized data line sample |
| start | input | 1 | START detected pulse |
| stop | input | 1 | STOP detected pulse |
| arb_in | input | 1 | Arbitration lost pulse |
| scl_drv | input | 1 | Request to pull the clock line low |
| sda_drv | input | 1 | Request to pull the data line low |
| load_o | output | 1 | Load the shift register |
| shift_o | output | 1 | Shift one data bit |
| rx_bit | output | 1 | Last sampled data bit |
| scl_oe | output | 1 | Clock pin output enable |
| sda_oe | output | 1 | Data pin output enable |
| bit_cnt_o | output | 3 | Current count field |
| pend_o | output | 1 | Byte complete, interrupt pending |
| busy_o | output | 1 | Bus busy |
| arb_o | output | 1 | Arbitration lost |

## Verification
The assertions check on every cycle the one-cycle consequences of single events. These are: a completion setting the pending flag and clearing the field, START forcing busy and a cleared count, STOP clearing busy, arbitration setting its flag, a load clearing pending, and disable forcing the idle flag values. Some behaviour spans a whole byte, and only the bench scenarios can show it. That covers the exact number of shift pulses per field value, the extra acknowledge edge, the absence of an early completion, and the START-versus-edge collision. The same holds for writes ignored while disabled.

// File: rtl/i2c_byte_seq.sv
module i2c_byte_seq #(
  parameter int CW = 3
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          en,
  input  logic          cnt_wr,
  input  logic [CW-1:0] cnt_val,
  input  logic          ack_en,
  input  logic          data_wr,
  input  logic          scl_in,
  input  logic          sda_in,
  input  logic          start,
  input  logic          stop,
  input  logic          arb_in,
  input  logic          scl_drv,
  input  logic          sda_drv,
  output logic          load_o,
  output logic          shift_o,
  output logic          rx_bit,
  output logic          scl_oe,
  output logic          sda_oe,
  output logic [CW-1:0] bit_cnt_o,
  output logic          pend_o,
  output logic          busy_o,
  output logic          arb_o
);
  localparam int MAXB = 1 << CW;
  localparam int TW   = CW + 2;

  logic          scl_q, active;
  logic [CW-1:0] fld;
  logic [TW-1:0] cnt;

  wire [TW-1:0] nbits  = TW'(MAXB) - TW'(fld);
  wire [TW-1:0] target = nbits + TW'(ack_en);
  wire          rise   = en & scl_in & ~scl_q;
  wire          go     = en & (start | data_wr);
  wire          step   = rise & active & ~go;
  wire          done   = step & ((cnt + TW'(1)) == target);

  assign shift_o   = step & (cnt < nbits);
  assign load_o    = en & data_wr;
  assign scl_oe    = en & scl_drv;
  assign sda_oe    = en & sda_drv;
  assign bit_cnt_o = fld;

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) scl_q <= 1'b0;
    else        scl_q <= scl_in;

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n)              fld <= '0;
    else if (en && start)    fld <= '0;
    else if (cnt_wr)         fld <= cnt_val;
    else if (done)           fld <= '0;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pend_o <= 1'b1; busy_o <= 1'b0; arb_o <= 1'b0;
      active <= 1'b0; cnt <= '0;  rx_bit <= 1'b0;
    end else if (!en) begin
      pend_o <= 1'b1; busy_o <= 1'b0; arb_o <= 1'b0;
      active <= 1'b0; cnt <= '0;
    end else begin
      if (go) begin
        cnt <= '0; active <= 1'b1;
      end else if (done) begin
        cnt <= '0; active <= 1'b0;
      end else if (step) begin
        cnt <= cnt + TW'(1);
      end
      if (load_o)    pend_o <= 1'b0;
      else if (done) pend_o <= 1'b1;
      if (start)     busy_o <= 1'b1;
      else if (stop) busy_o <= 1'b0;
      if (arb_in)    arb_o <= 1'b1;
      else if (go)   arb_o <= 1'b0;
      if (shift_o)   rx_bit <= sda_in;
    end
  end

  // R3
  done_flag_chk: assert property (@(posedge clk) disable iff (!rst_n)
    done && !cnt_wr |=> pend_o && bit_cnt_o == '0);
  // R4
  start_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
    en && start |=> busy_o && bit_cnt_o == '0 && cnt == '0);
  // R6
  stop_free_chk: assert property (@(posedge clk) disable iff (!rst_n)
    en && stop && !start |=> !busy_o);
  // R7
  arb_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
    en && arb_in |=> arb_o);
  // R8
  load_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
    load_o |=> !pend_o && cnt == '0);
  // R9
  idle_flags_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !en |=> pend_o && !busy_o && !arb_o);
endmodule

// File: tb/test_i2c_byte_seq.sv
`timescale 1ns/1ps
module test_i2c_byte_seq;
  logic clk = 0, rst_n = 0, en = 0, cnt_wr = 0, ack_en = 0, data_wr = 0;
  logic scl_in = 0, sda_in = 0, start = 0, stop = 0, arb_in = 0;
  logic scl_drv = 0, sda_drv = 0;
  logic [2:0] cnt_val = 0;
  logic load_o, shift_o, rx_bit, scl_oe, sda_oe, pend_o, busy_o, arb_o;
  logic [2:0] bit_cnt_o;
  int errors = 0, checks = 0, shifts = 0;

  always #2.5 clk = ~clk;

  i2c_byte_seq i_i2c_byte_seq (.*);

  // {field, ack, edges to completion}
  localparam logic [7:0] VEC [11] = '{
    {3'd0,1'b0,4'd8}, {3'd1,1'b0,4'd7}, {3'd2,1'b0,4'd6}, {3'd3,1'b0,4'd5},
    {3'd4,1'b0,4'd4}, {3'd5,1'b0,4'd3}, {3'd6,1'b0,4'd2}, {3'd7,1'b0,4'd1},
    {3'd0,1'b1,4'd9}, {3'd7,1'b1,4'd2}, {3'd3,1'b1,4'd6}};

  task automatic chk(string req, int act, int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s: actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic edge_clk();
    @(negedge clk); scl_in = 1; #1; if (shift_o) shifts++;
    @(negedge clk); scl_in = 0;
    @(negedge clk);
  endtask

  task automatic wr_cnt(input logic [2:0] v);
    @(negedge clk); cnt_wr = 1; cnt_val = v; @(negedge clk); cnt_wr = 0;
  endtask

  task automatic wr_data();
    @(negedge clk); data_wr = 1; @(negedge clk); data_wr = 0;
  endtask

  initial begin
    #900000;
    errors++; checks++;
    $display("FAIL watchdog: actual=hang expected=finish");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    // R10 reset values
    chk("R10 pend", pend_o, 1); chk("R10 busy", busy_o, 0);
    chk("R10 arb", arb_o, 0);   chk("R10 field", bit_cnt_o, 0);
    rst_n = 1; @(negedge clk);
    en = 1; @(negedge clk);

    // R1 R2 R3 table of field and ack settings
    foreach (VEC[i]) begin
      logic [2:0] f; logic a; int n; int early;
      f = VEC[i][7:5]; a = VEC[i][4]; n = int'(VEC[i][3:0]);
      ack_en = a;
      wr_cnt(f);
      wr_data();
      shifts = 0; early = 0;
      for (int k = 1; k <= n; k++) begin
        edge_clk();
        if (k < n && pend_o) early++;
      end
      chk(a ? "R2 no early pend" : "R3 no early pend", early, 0);
      chk("R1 shift count", shifts, 8 - f);
      chk(a ? "R2 pend after ack" : "R3 pend at end", pend_o, 1);
      chk("R3 field cleared", bit_cnt_o, 0);
    end
    ack_en = 0;

    // R8 load pulse and pend clear
    @(negedge clk); data_wr = 1; #1; chk("R8 load", load_o, 1);
    @(negedge clk); data_wr = 0; chk("R8 pend cleared", pend_o, 0);

    // R4 START forces 8-bit byte
    wr_cnt(3'd5);
    @(negedge clk); start = 1; @(negedge clk); start = 0;
    chk("R4 field", bit_cnt_o, 0); chk("R4 busy", busy_o, 1);
    shifts = 0;
    for (int k = 1; k <= 7; k++) edge_clk();
    chk("R4 not done at 7", pend_o, 0);
    edge_clk();
    chk("R4 done at 8", pend_o, 1); chk("R4 shifts", shifts, 8);

    // R5 START and edge collide
    wr_data();
    edge_clk(); edge_clk();
    @(negedge clk); scl_in = 1; start = 1; #1;
    chk("R5 no shift", shift_o, 0);
    @(negedge clk); start = 0; scl_in = 0; @(negedge clk);
    shifts = 0;
    for (int k = 1; k <= 7; k++) edge_clk();
    chk("R5 not done at 7", pend_o, 0);
    edge_clk();
    chk("R5 done at 8", pend_o, 1); chk("R5 shifts", shifts, 8);

    // R6 STOP frees bus
    @(negedge clk); stop = 1; @(negedge clk); stop = 0;
    chk("R6 busy", busy_o, 0);

    // R7 arbitration flag
    @(negedge clk); arb_in = 1; @(negedge clk); arb_in = 0;
    chk("R7 set", arb_o, 1);
    wr_data();
    chk("R7 cleared", arb_o, 0);

    // R9 disable
    @(negedge clk); start = 1; arb_in = 1; @(negedge clk); start = 0; arb_in = 0;
    scl_drv = 1; sda_drv = 1; #1;
    chk("R9 oe on", scl_oe & sda_oe, 1);
    @(negedge clk); en = 0; #1;
    chk("R9 scl_oe", scl_oe, 0); chk("R9 sda_oe", sda_oe, 0);
    @(negedge clk);
    chk("R9 pend", pend_o, 1); chk("R9 busy", busy_o, 0); chk("R9 arb", arb_o, 0);
    @(negedge clk); data_wr = 1; #1; chk("R9 no load", load_o, 0);
    @(negedge clk); data_wr = 0;
    shifts = 0; edge_clk();
    chk("R9 no shift", shifts, 0);
    en = 1; @(negedge clk);
    chk("R9 pend kept", pend_o, 1);

    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule